// File: doc/BRIEF.md
# Programmable Reset Supervisor Timer

This block turns two supply-health flags into an active-low reset output. One flag is high while the supply sits under its trip threshold. The other is high while the supply is under the power-on level. Either flag pulls the reset output low at once, through a combinational path. When both flags have cleared, the output stays low for a hold time and is then released. The hold time is counted in pulses of a millisecond tick input.

A delay code selects the hold time. The code is held in a register that the surrounding configuration logic writes. Software can also request a reset. The request sets a software-reset bit, pulls the output low for the same hold time, and the bit then clears itself. The block also gives three flags for a configuration register: supply ready, trip point and reset status.

Top module: `supv_reset_timer`

## Requirements
- R1: The delay code selects a hold of BASE_TICKS << code ticks. With the default BASE_TICKS=125, codes 0, 1, 2 and 3 give 125, 250, 500 and 1000 ticks. The output is released on the clock edge that samples the last of those ticks.
- R2: Reset sets the delay code to all ones (3). When reset is released with both supply flags low, `rst_out_n` stays low for 1000 ticks and is then released.
- R3: A one-cycle pulse on `code_wr` loads `code_in` into `delay_code` on the next clock edge.
- R4: While `below_trip` or `below_por` is high, `rst_out_n` is low in the same cycle, with no clock edge needed.
- R5: A pulse on `swrst_req` sets `swrst_bit` and pulls `rst_out_n` low. After the hold time, both clear together.
- R6: `stat_trip` reads 1 while `below_trip` is high and reads 0 otherwise.
- R7: `stat_rst` reads 1 exactly while `rst_out_n` is low.
- R8: A supply flag or a software request that comes while a hold is running restarts the hold count from zero.
- R9: The hold uses the delay code as it was when the hold began from idle. A code written during a hold takes effect only on the next hold.
- R10: `stat_ready` reads 0 while `below_por` is low and reads 1 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| below_trip | input | 1 | Supply is under the trip threshold |
| below_por | input | 1 | Supply is under the power-on level |
| code_wr | input | 1 | Write strobe for the delay code |
| code_in | input | CODE_W | New delay code |
| swrst_req | input | 1 | Software reset request pulse |
| rst_out_n | output | 1 | Active-low reset output |
| delay_code | output | CODE_W | Current delay code register |
| swrst_bit | output | 1 | Software-reset bit; clears itself |
| stat_ready | output | 1 | Reads 0 once the supply is above the power-on level |
| stat_trip | output | 1 | Supply is under the trip threshold |
| stat_rst | output | 1 | Reset output is active |

## Verification
The assertions assume that `ms_tick` is a single-cycle enable and that the supply flags are already synchronous to `clk`. They also assume that the flags, `code_wr` and `swrst_req` change only between clock edges. The stimulus drives every input on the falling clock edge. Ticks are pulses one cycle long, spaced two cycles apart. Supply dips last one or more whole cycles. This keeps every counted hold an exact whole number of ticks, so release counts can be compared exactly.

// File: rtl/supv_reset_timer.sv
module supv_reset_timer #(
  parameter int BASE_TICKS = 125,
  parameter int CODE_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              below_trip,
  input  logic              below_por,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_in,
  input  logic              swrst_req,
  output logic              rst_out_n,
  output logic [CODE_W-1:0] delay_code,
  output logic              swrst_bit,
  output logic              stat_ready,
  output logic              stat_trip,
  output logic              stat_rst
);
  localparam int MAX_TICKS = BASE_TICKS << ((1 << CODE_W) - 1);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic              hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] cur_code;
  logic [CNT_W-1:0]  limit;
  logic              fault, done;

  assign fault = below_trip | below_por;
  assign limit = CNT_W'(BASE_TICKS) << cur_code;
  assign done  = hold_q & ~fault & ~swrst_req & ms_tick & (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b1;
      cnt_q      <= '0;
      delay_code <= '1;
      cur_code   <= '1;
      swrst_bit  <= 1'b0;
    end else begin
      if (code_wr) delay_code <= code_in;
      if (fault | swrst_req) begin
        if (!hold_q) cur_code <= delay_code;
        hold_q <= 1'b1;
        cnt_q  <= '0;
      end else if (hold_q && ms_tick) begin
        if (done) begin
          hold_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (swrst_req) swrst_bit <= 1'b1;
      else if (done) swrst_bit <= 1'b0;
    end
  end

  assign rst_out_n  = ~(hold_q | fault);
  assign stat_rst   = ~rst_out_n;
  assign stat_trip  = below_trip;
  assign stat_ready = below_por;

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> cnt_q < limit);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> hold_q && cnt_q == '0);
  a_r5_sw_clears_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swrst_bit) |-> !hold_q);
  a_r1_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(ms_tick) && !$past(fault));
  a_r9_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q)) |-> $stable(cur_code));
  a_r4_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    below_trip |-> !rst_out_n);
endmodule

// File: tb/supv_reset_timer_test.sv
module supv_reset_timer_test;
  logic clk = 0, rst_n = 0, ms_tick = 0, below_trip = 0, below_por = 0;
  logic code_wr = 0, swrst_req = 0;
  logic [1:0] code_in = 0;
  logic rst_out_n, swrst_bit, stat_ready, stat_trip, stat_rst;
  logic [1:0] delay_code;
  int total = 0, bad = 0, n;
  bit finished = 0;

  always #5 clk = ~clk;

  supv_reset_timer uut (.clk, .rst_n, .ms_tick, .below_trip, .below_por, .code_wr,
    .code_in, .swrst_req, .rst_out_n, .delay_code, .swrst_bit, .stat_ready,
    .stat_trip, .stat_rst);

  localparam int VEC_N = 4;
  localparam logic [1:0] VCODE [VEC_N] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam int VTICKS [VEC_N] = '{125, 250, 500, 1000};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1;
    @(negedge clk) ms_tick = 0;
  endtask

  task automatic measure(output int cnt);
    cnt = -1;
    for (int i = 1; i <= 3000; i++) begin
      tick();
      if (rst_out_n) begin cnt = i; return; end
    end
  endtask

  task automatic write_code(input logic [1:0] c);
    @(negedge clk) begin code_wr = 1; code_in = c; end
    @(negedge clk) code_wr = 0;
  endtask

  task automatic sw_pulse();
    @(negedge clk) swrst_req = 1;
    @(negedge clk) swrst_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset out", rst_out_n, 0);
    check("R2 reset code", delay_code, 3);
    check("R5 reset swbit", swrst_bit, 0);
    rst_n = 1;
    measure(n);
    check("R2 power-on hold", n, 1000);
    check("R7 released", stat_rst, 0);

    for (int v = 0; v < VEC_N; v++) begin
      write_code(VCODE[v]);
      check("R3 code write", delay_code, VCODE[v]);
      sw_pulse();
      check("R5 sw bit set", swrst_bit, 1);
      check("R5 sw asserts", rst_out_n, 0);
      measure(n);
      check("R1 hold ticks", n, VTICKS[v]);
      check("R5 sw bit cleared", swrst_bit, 0);
    end

    @(negedge clk) below_trip = 1;
    #1;
    check("R4 immediate", rst_out_n, 0);
    check("R6 trip set", stat_trip, 1);
    check("R7 status set", stat_rst, 1);
    @(negedge clk) below_trip = 0;
    #1 check("R6 trip clear", stat_trip, 0);
    measure(n);
    check("R1 trip hold code3", n, 1000);

    write_code(0);
    sw_pulse();
    repeat (100) tick();
    @(negedge clk) below_trip = 1;
    @(negedge clk) below_trip = 0;
    check("R8 still held", rst_out_n, 0);
    measure(n);
    check("R8 restart", n, 125);

    write_code(0);
    sw_pulse();
    repeat (10) tick();
    write_code(1);
    measure(n);
    check("R9 old code used", n, 115);
    sw_pulse();
    measure(n);
    check("R9 new code next", n, 250);

    @(negedge clk) below_por = 1;
    #1;
    check("R10 ready high", stat_ready, 1);
    check("R4 por asserts", rst_out_n, 0);
    @(negedge clk) below_por = 0;
    #1 check("R10 ready low", stat_ready, 0);
    measure(n);
    check("R1 por hold", n, 250);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule